// File: doc/BRIEF.md
# Thermal Event Trigger with Adaptive Timeout

This block sits between an on-chip temperature sensor and the core that runs a software thermal controller. The sensor presents a signed temperature value together with a one-cycle strobe once every sample period. The block decides, sample by sample, whether the controller needs to run. It raises an interrupt when the new reading has drifted far enough from the reading taken at the previous event, or when too many sample periods have passed without any event. Software is thus woken only when the temperature actually moves, with a slow keep-alive beat otherwise.

The timeout length adapts in hardware. Each timeout event doubles the allowed number of quiet sample periods, up to a programmable ceiling. A threshold event sets it back to a single period, so the controller runs again on the very next sample. At every event the block keeps the triggering sample and the sample before it. Software reads these together with a cause flag through a small register port. It acknowledges the interrupt through the same port. A sticky overrun flag records any event that arrived while an earlier one was still unacknowledged.

Top module: `thermal_event_gen`

## Requirements
- R1: After reset the interrupt is low, the status word reads 0, the timeout limit (address 5) reads 1, and the latched samples (addresses 3 and 4) read 0.
- R2: On a strobe, a threshold event occurs when |sample − reference| is strictly greater than the delta register (address 1, 13-bit unsigned). A difference equal to delta raises no event. Both signs of drift trigger.
- R3: A quiet-period counter advances by one on each strobe. When the incremented count reaches the timeout limit, a timeout event occurs. Any event clears the counter and replaces the reference with the current sample. Without a strobe, the limit does not change.
- R4: Status bit 1 (address 0) is 1 for a threshold cause and 0 for a timeout cause. When both conditions hold on the same strobe, the cause is threshold.
- R5: After a timeout event the limit becomes min(2 × limit, ceiling), where the ceiling is the register at address 2 (16 bits). The limit is never 0.
- R6: After a threshold event the limit becomes 1.
- R7: At each event, address 3 holds the triggering sample and address 4 holds the sample of the strobe before it. Both are sign-extended to 16 bits and stay unchanged until the next event.
- R8: An event sets the pending flag (status bit 0) and drives the interrupt high, one cycle after the strobe. The interrupt stays high until a write to address 0 with data bit 0 set.
- R9: An event while the pending flag is set and not being acknowledged in that cycle sets the sticky overrun flag (status bit 2). A write to address 0 with data bit 2 set clears it.
- R10: The difference is formed one bit wider than the sample, so the full-scale difference 4095 (2047 versus −2048) compares correctly.
- R11: The register map is: 0 status/control, 1 delta, 2 ceiling, 3 latched sample, 4 previous sample, 5 current limit. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | One-cycle strobe marking a new temperature sample |
| smp_temp_i | input | TW (12) | Signed temperature sample |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt toward the controller core |

## Verification
The bench steers the limit through the full doubling sequence into the ceiling. A design that wrapped or failed to clamp would show 16 instead of 8 there. It places one sample at exactly delta from the reference and the next at delta plus one, in the negative direction, to catch a non-strict compare or a lost sign. It drives full-scale opposite extremes to expose a difference computed at sample width, which would wrap and miss the event. It also produces coincident threshold and timeout conditions, where a wrong priority reports a timeout cause and doubles the limit instead of resetting it. Unacknowledged back-to-back events check the overrun flag, and a design that lost it would read status 1 instead of 5.

// File: rtl/thermal_evt_pkg.sv
package thermal_evt_pkg;

    localparam int RW = 16;   // register bus width
    localparam int AW = 3;    // register address width

    typedef enum logic [AW-1:0] {
        ADR_STAT  = 3'd0,
        ADR_DELTA = 3'd1,
        ADR_CEIL  = 3'd2,
        ADR_CUR   = 3'd3,
        ADR_PREV  = 3'd4,
        ADR_LIMIT = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic overrun;
        logic cause_thr;
        logic pending;
    } evt_status_t;

    localparam int ACK_BIT = 0;
    localparam int OVC_BIT = 2;

endpackage

// File: rtl/thermal_delta_cmp.sv
module thermal_delta_cmp #(
    parameter int TW = 12
) (
    input  logic signed [TW-1:0] sample,
    input  logic signed [TW-1:0] refv,
    input  logic        [TW:0]   delta,
    output logic                 over
);
    localparam int XW = TW + 1;

    logic signed [XW-1:0] diff;
    logic        [XW-1:0] mag;

    always_comb begin
        diff = XW'(sample) - XW'(refv);
        mag  = diff[XW-1] ? XW'(-diff) : XW'(diff);
        over = (mag > delta);
    end
endmodule

// File: rtl/thermal_timeout.sv
module thermal_timeout #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          evt,
    input  logic          evt_thr,
    input  logic [CW-1:0] ceiling,
    output logic          tmo,
    output logic [CW-1:0] limit
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic [CW:0]   dbl;
    logic [CW-1:0] grown;

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        tmo     = strobe && (cnt_inc >= limit);
        dbl     = {limit, 1'b0};
        grown   = (dbl > {1'b0, ceiling}) ? ceiling : dbl[CW-1:0];
        if (grown == '0) grown = CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            limit <= CW'(1);
        end else if (evt) begin
            cnt_q <= '0;
            limit <= evt_thr ? CW'(1) : grown;
        end else if (strobe) begin
            cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/thermal_regs.sv
module thermal_regs
    import thermal_evt_pkg::*;
#(
    parameter int TW        = 12,
    parameter int CW        = 16,
    parameter int DELTA_RST = 16,
    parameter int CEIL_RST  = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  logic signed [TW-1:0] sample,
    input  logic                 evt,
    input  logic                 evt_thr,
    input  logic                 reg_wr,
    input  logic [AW-1:0]        reg_addr,
    input  logic [RW-1:0]        reg_wdata,
    input  logic [CW-1:0]        limit,
    output logic [TW:0]          delta,
    output logic [CW-1:0]        ceiling,
    output logic signed [TW-1:0] refv,
    output logic signed [TW-1:0] cur_q,
    output evt_status_t          stat_q,
    output logic [RW-1:0]        rdata
);
    logic signed [TW-1:0] last_q;
    logic signed [TW-1:0] prev_q;
    logic                 ack_wr;
    logic                 ovc_wr;

    assign ack_wr = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[ACK_BIT];
    assign ovc_wr = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[OVC_BIT];

    function automatic logic [RW-1:0] sext(input logic signed [TW-1:0] v);
        return {{(RW-TW){v[TW-1]}}, v};
    endfunction

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            delta   <= (TW+1)'(DELTA_RST);
            ceiling <= CW'(CEIL_RST);
        end else if (reg_wr) begin
            if (reg_addr == ADR_DELTA) delta   <= reg_wdata[TW:0];
            if (reg_addr == ADR_CEIL)  ceiling <= reg_wdata[CW-1:0];
        end
    end

    // sample capture
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            refv   <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else if (strobe) begin
            last_q <= sample;
            if (evt) begin
                refv   <= sample;
                cur_q  <= sample;
                prev_q <= last_q;
            end
        end
    end

    // event status
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            if (evt) begin
                stat_q.pending   <= 1'b1;
                stat_q.cause_thr <= evt_thr;
            end else if (ack_wr) begin
                stat_q.pending   <= 1'b0;
            end
            if (evt && stat_q.pending && !ack_wr)
                stat_q.overrun <= 1'b1;
            else if (ovc_wr)
                stat_q.overrun <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADR_STAT:  rdata = RW'(stat_q);
            ADR_DELTA: rdata = RW'(delta);
            ADR_CEIL:  rdata = RW'(ceiling);
            ADR_CUR:   rdata = sext(cur_q);
            ADR_PREV:  rdata = sext(prev_q);
            ADR_LIMIT: rdata = RW'(limit);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/thermal_event_gen.sv
module thermal_event_gen
    import thermal_evt_pkg::*;
#(
    parameter int TW        = 12,
    parameter int CW        = 16,
    parameter int DELTA_RST = 16,
    parameter int CEIL_RST  = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid_i,
    input  logic signed [TW-1:0] smp_temp_i,
    input  logic                 reg_wr_i,
    input  logic [AW-1:0]        reg_addr_i,
    input  logic [RW-1:0]        reg_wdata_i,
    output logic [RW-1:0]        reg_rdata_o,
    output logic                 irq_o
);
    logic                 over;
    logic                 tmo;
    logic                 evt;
    logic                 evt_thr;
    logic [TW:0]          delta;
    logic [CW-1:0]        ceiling;
    logic [CW-1:0]        limit;
    logic signed [TW-1:0] refv;
    logic signed [TW-1:0] cur_q;
    evt_status_t          stat_q;

    thermal_delta_cmp #(.TW(TW)) u_cmp (
        .sample (smp_temp_i),
        .refv   (refv),
        .delta  (delta),
        .over   (over)
    );

    assign evt_thr = smp_valid_i && over;
    assign evt     = evt_thr || tmo;

    thermal_timeout #(.CW(CW)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .strobe  (smp_valid_i),
        .evt     (evt),
        .evt_thr (evt_thr),
        .ceiling (ceiling),
        .tmo     (tmo),
        .limit   (limit)
    );

    thermal_regs #(
        .TW(TW), .CW(CW), .DELTA_RST(DELTA_RST), .CEIL_RST(CEIL_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .strobe    (smp_valid_i),
        .sample    (smp_temp_i),
        .evt       (evt),
        .evt_thr   (evt_thr),
        .reg_wr    (reg_wr_i),
        .reg_addr  (reg_addr_i),
        .reg_wdata (reg_wdata_i),
        .limit     (limit),
        .delta     (delta),
        .ceiling   (ceiling),
        .refv      (refv),
        .cur_q     (cur_q),
        .stat_q    (stat_q),
        .rdata     (reg_rdata_o)
    );

    assign irq_o = stat_q.pending;
endmodule

// File: rtl/thermal_event_gen_chk.sv
module thermal_event_gen_chk #(
    parameter int TW = 12,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_valid,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [15:0]   reg_wdata,
    input logic          irq,
    input logic          evt,
    input logic          evt_thr,
    input logic          overrun,
    input logic [CW-1:0] limit,
    input logic [TW-1:0] cur
);
    logic ack_now;
    logic ovc_now;
    assign ack_now = reg_wr && (reg_addr == 3'd0) && reg_wdata[0];
    assign ovc_now = reg_wr && (reg_addr == 3'd0) && reg_wdata[2];

    assert_limit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(limit));

    assert_limit_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        limit != '0);

    assert_thr_snap_R6: assert property (@(posedge clk) disable iff (rst)
        evt_thr |=> (limit == CW'(1)));

    assert_cur_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(cur));

    assert_evt_irq_R8: assert property (@(posedge clk) disable iff (rst)
        evt |=> irq);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack_now) |=> irq);

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovc_now) |=> overrun);

    assert_ovr_set_R9: assert property (@(posedge clk) disable iff (rst)
        (evt && irq && !ack_now) |=> overrun);
endmodule

bind thermal_event_gen thermal_event_gen_chk #(.TW(TW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid_i),
    .reg_wr    (reg_wr_i),
    .reg_addr  (reg_addr_i),
    .reg_wdata (reg_wdata_i),
    .irq       (irq_o),
    .evt       (evt),
    .evt_thr   (evt_thr),
    .overrun   (stat_q.overrun),
    .limit     (limit),
    .cur       (cur_q)
);

// File: tb/thermal_event_gen_tb.sv
module thermal_event_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid_i = 1'b0;
    logic [11:0] smp_temp_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    thermal_event_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .smp_valid_i (smp_valid_i),
        .smp_temp_i  (smp_temp_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr_i = a;
        #1;
        v = int'(reg_rdata_o);
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input int exp);
        int v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = 16'(d);
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic smp(input int t);
        @(negedge clk);
        smp_valid_i = 1'b1; smp_temp_i = 12'(t);
        @(negedge clk);
        smp_valid_i = 1'b0;
    endtask

    task automatic ack();
        wr(3'd0, 1);
    endtask

    task automatic t_reset();
        check("R1 irq", int'(irq_o), 0);
        chk_reg("R1 status", 3'd0, 0);
        chk_reg("R1 limit", 3'd5, 1);
        chk_reg("R1 cur", 3'd3, 0);
        chk_reg("R1 prev", 3'd4, 0);
        chk_reg("R11 delta reset", 3'd1, 16);
        chk_reg("R11 ceiling reset", 3'd2, 1000);
    endtask

    task automatic t_first_timeout();
        wr(3'd1, 100);
        wr(3'd2, 8);
        chk_reg("R11 delta write", 3'd1, 100);
        smp(50);
        check("R8 irq on event", int'(irq_o), 1);
        chk_reg("R3 R4 timeout cause", 3'd0, 1);
        chk_reg("R7 cur", 3'd3, 50);
        chk_reg("R7 prev", 3'd4, 0);
        chk_reg("R5 limit 2", 3'd5, 2);
        smp(50);
        ack();
        check("R8 ack clears", int'(irq_o), 0);
    endtask

    task automatic t_doubling();
        // counter holds 1 from the quiet strobe above; limit 2
        smp(53);
        chk_reg("R7 prev on timeout", 3'd4, 50);
        chk_reg("R5 limit 4", 3'd5, 4);
        ack();
        for (int i = 0; i < 3; i++) smp(54 + i);
        check("R3 no early timeout", int'(irq_o), 0);
        smp(57);
        check("R3 timeout after 4", int'(irq_o), 1);
        chk_reg("R7 prev", 3'd4, 56);
        chk_reg("R5 limit 8", 3'd5, 8);
        ack();
        for (int i = 0; i < 7; i++) smp(57);
        check("R3 quiet 7", int'(irq_o), 0);
        smp(57);
        check("R3 timeout after 8", int'(irq_o), 1);
        chk_reg("R5 capped at ceiling", 3'd5, 8);
        ack();
    endtask

    task automatic t_threshold();
        smp(157);
        check("R2 equal delta no event", int'(irq_o), 0);
        smp(-44);
        check("R2 negative drift event", int'(irq_o), 1);
        chk_reg("R4 threshold cause", 3'd0, 3);
        chk_reg("R6 limit back to 1", 3'd5, 1);
        chk_reg("R7 cur sign ext", 3'd3, 16'hFFD4);
        chk_reg("R7 prev", 3'd4, 157);
        ack();
    endtask

    task automatic t_overrun();
        smp(-40);
        chk_reg("R3 R4 timeout at limit 1", 3'd0, 1);
        chk_reg("R5 limit 2", 3'd5, 2);
        smp(-39);
        smp(-38);
        chk_reg("R9 overrun set", 3'd0, 5);
        check("R8 irq held", int'(irq_o), 1);
        wr(3'd0, 4);
        chk_reg("R9 overrun cleared", 3'd0, 1);
        ack();
        chk_reg("R8 pending cleared", 3'd0, 0);
    endtask

    task automatic t_full_scale();
        wr(3'd1, 0);
        smp(2047);
        chk_reg("R2 delta 0 any change", 3'd0, 3);
        ack();
        wr(3'd1, 4094);
        smp(-2048);
        chk_reg("R10 R4 full-scale threshold wins", 3'd0, 3);
        chk_reg("R6 limit 1", 3'd5, 1);
        chk_reg("R10 cur", 3'd3, 16'hF800);
        ack();
        smp(-2048);
        chk_reg("R4 pure timeout", 3'd0, 1);
        chk_reg("R5 limit 2", 3'd5, 2);
        ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_timeout();
        t_doubling();
        t_threshold();
        t_overrun();
        t_full_scale();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule